// File: doc/BRIEF.md
# Gated Non-Retriggerable One-Shot Pulser

This block is a clocked monostable with several independent channels (two by default). Each channel has two trigger inputs of opposite polarity. The first fires on a falling edge and the second fires on a rising edge. Each trigger input also acts as an enable for the other. When a channel fires, it drives a pulse on its `q` output. The pulse lasts a number of clock cycles given by that channel's width input. The `q_n` output is always the inverse of `q`.

While a pulse is running, the channel ignores every trigger transition. The pulse therefore cannot be stretched or restarted. An active-low clear aborts a running pulse and holds the channel idle. A trigger edge counts only after clear has been high for at least one full clock cycle. All inputs must already be synchronous to `clk`. Edges are found by comparing each input with its value on the previous clock.

Top module: `dual_oneshot`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), every channel is idle, with `q` low and `q_n` high.
- R2: A falling edge on `trig_fall_n[c]` fires channel c when `trig_rise[c]` is high and clear has been high for at least one cycle. `q[c]` rises at the clock edge that follows the cycle in which the falling level is first seen.
- R3: A rising edge on `trig_rise[c]` fires channel c when `trig_fall_n[c]` is low and clear has been high for at least one cycle. The output timing is the same as in R2.
- R4: While `trig_fall_n[c]` is high, or while `trig_rise[c]` is low, no pulse starts on channel c, whatever the other trigger does.
- R5: A pulse keeps `q[c]` high for exactly the number of cycles on `width_cnt` slice c (bits c*CNT_W upward), sampled when the pulse fires. A value of 0 gives a pulse of one cycle.
- R6: While a pulse is running, transitions on either trigger neither shorten, lengthen nor restart it.
- R7: A clock edge that sees `clr_n[c]` low sets `q[c]` low. It stays low for as long as clear stays low, whatever the triggers do.
- R8: A trigger edge in the same cycle that `clr_n[c]` returns high is ignored.
- R9: `q_n` is the bitwise complement of `q` in every cycle.
- R10: A qualifying edge seen in the cycle right after `q[c]` falls starts a new pulse. An edge seen during the last high cycle of a pulse is ignored.
- R11: Channels are independent: the triggers, clear and width of one channel never affect another channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_fall_n | input | NUM_CH | Falling-edge trigger per channel; a high level inhibits that channel |
| trig_rise | input | NUM_CH | Rising-edge trigger per channel; a low level inhibits that channel |
| clr_n | input | NUM_CH | Active-low clear per channel |
| width_cnt | input | NUM_CH*CNT_W | Pulse length in cycles, one CNT_W slice per channel |
| q | output | NUM_CH | Pulse output per channel |
| q_n | output | NUM_CH | Complement of q |

## Verification
The hardest cases to reach are the one-cycle boundaries. One is an edge that lands exactly in the last high cycle of a pulse, or in the cycle just after it. The other is an edge that arrives in the same cycle that clear is released. The stimulus reaches these cases by driving each input on the falling clock edge at a counted offset from the triggering edge. It uses a short programmed width so that the pulse's end falls on a known cycle. The first trigger falls low ahead of time so that the second trigger's rising edge alone decides the cycle.

// File: rtl/dual_oneshot_pkg.sv
// Package: shared types for the one-shot pulser.
// Holds the per-channel event bundle passed from edge tracking to firing logic.
package dual_oneshot_pkg;

    // Edge events of one channel, valid for the current cycle
    typedef struct packed {
        logic a_fall;     // falling-trigger input went 1 -> 0
        logic b_rise;     // rising-trigger input went 0 -> 1
        logic clr_ready;  // clear high now and in the previous cycle
    } edge_evt_t;

endpackage

// File: rtl/oneshot_edge_track.sv
// Module: oneshot_edge_track
// Registers one channel's trigger and clear inputs and reports the edges
// seen this cycle. Assumes inputs are already synchronous to clk.
// Reset values are chosen so that no edge is reported just after reset.
module oneshot_edge_track
    import dual_oneshot_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      a_in,
    input  logic      b_in,
    input  logic      clr_in_n,
    output edge_evt_t evt
);

    logic a_q;
    logic b_q;
    logic clr_q;

    // Keep last-cycle copies of the inputs for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= 1'b0;
            b_q   <= 1'b1;
            clr_q <= 1'b0;
        end else begin
            a_q   <= a_in;
            b_q   <= b_in;
            clr_q <= clr_in_n;
        end
    end

    // Derive edge events from current versus previous values
    always_comb begin
        evt.a_fall    = a_q & ~a_in;
        evt.b_rise    = ~b_q & b_in;
        evt.clr_ready = clr_in_n & clr_q;
    end

    // R8: a clear that rises this cycle never counts as settled
    a_r8_clear_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr_in_n) |-> !evt.clr_ready);

endmodule

// File: rtl/oneshot_fire_qual.sv
// Module: oneshot_fire_qual
// Decides whether a channel fires this cycle. The edge must be gated by the
// other trigger's level, clear must be settled and no pulse may be running.
// Purely combinational.
module oneshot_fire_qual
    import dual_oneshot_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  edge_evt_t evt,
    input  logic      a_lvl,
    input  logic      b_lvl,
    input  logic      busy,
    output logic      fire
);

    logic via_a;
    logic via_b;

    // Qualify each trigger path by the opposite input's level
    always_comb begin
        via_a = evt.a_fall & b_lvl;
        via_b = evt.b_rise & ~a_lvl;
        fire  = evt.clr_ready & ~busy & (via_a | via_b);
    end

    // R4: a high falling-trigger level blocks any start
    a_r4_inhibit_a: assert property (@(posedge clk) disable iff (!rst_n)
        a_lvl |-> !fire);
    // R4: a low rising-trigger level blocks any start
    a_r4_inhibit_b: assert property (@(posedge clk) disable iff (!rst_n)
        !b_lvl |-> !fire);

endmodule

// File: rtl/oneshot_pulse_timer.sv
// Module: oneshot_pulse_timer
// Down-counter that holds q high for the programmed number of cycles.
// Assumes fire is asserted only while idle. Clear has priority over fire.
module oneshot_pulse_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             fire,
    input  logic [CNT_W-1:0] width,
    output logic             busy
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] load_val;

    // Treat a zero width as the one-cycle minimum
    always_comb begin
        load_val = (width == '0) ? ONE : width;
    end

    // Load on fire, count down while running, abort on clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (!clr_n) begin
            remain <= '0;
        end else if (fire) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - ONE;
        end
    end

    // Output is high while any cycles remain
    always_comb begin
        busy = (remain != '0);
    end

    // R7: a sampled clear ends any pulse at that edge
    a_r7_clear_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> !busy);
    // R6: a running pulse counts down undisturbed
    a_r6_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && remain > ONE) |=> (remain == $past(remain) - ONE));
    // R5: a start loads the sampled width, floored at one
    a_r5_load_width: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && fire) |=> (remain == (($past(width) == '0) ? ONE : $past(width))));

endmodule

// File: rtl/dual_oneshot.sv
// Module: dual_oneshot
// Top level: NUM_CH independent gated, non-retriggerable one-shot channels.
// Each channel chains edge tracking, fire qualification and a pulse timer.
// Assumes all inputs are synchronous to clk.
module dual_oneshot
    import dual_oneshot_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       trig_fall_n,
    input  logic [NUM_CH-1:0]       trig_rise,
    input  logic [NUM_CH-1:0]       clr_n,
    input  logic [NUM_CH*CNT_W-1:0] width_cnt,
    output logic [NUM_CH-1:0]       q,
    output logic [NUM_CH-1:0]       q_n
);

    localparam int WBUS = NUM_CH * CNT_W;

    logic [NUM_CH-1:0] busy;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        edge_evt_t  evt;
        logic       fire;

        oneshot_edge_track u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .a_in     (trig_fall_n[c]),
            .b_in     (trig_rise[c]),
            .clr_in_n (clr_n[c]),
            .evt      (evt)
        );

        oneshot_fire_qual u_qual (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (evt),
            .a_lvl (trig_fall_n[c]),
            .b_lvl (trig_rise[c]),
            .busy  (busy[c]),
            .fire  (fire)
        );

        oneshot_pulse_timer #(.CNT_W(CNT_W)) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_n (clr_n[c]),
            .fire  (fire),
            .width (width_cnt[c*CNT_W +: CNT_W]),
            .busy  (busy[c])
        );
    end

    // Drive the complementary outputs from the timers
    always_comb begin
        q   = busy;
        q_n = ~busy;
    end

    // R1: every channel is idle in the cycle after a reset edge
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (q == '0));

    initial begin
        if (WBUS != $bits(width_cnt)) $display("width bus size mismatch");
    end

endmodule

// File: tb/dual_oneshot_test.sv
// Bench for dual_oneshot: a behavioural per-cycle model plus directed scenarios.
module dual_oneshot_test;

    localparam int NCH = 2;
    localparam int CW  = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] a = '1;
    logic [NCH-1:0] b = '1;
    logic [NCH-1:0] clr = '1;
    logic [CW-1:0]  w0 = 8'd5;
    logic [CW-1:0]  w1 = 8'd5;
    logic [NCH-1:0] q;
    logic [NCH-1:0] q_n;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    // reference model state
    int m_rem [NCH];
    bit m_a   [NCH];
    bit m_b   [NCH];
    bit m_c   [NCH];

    dual_oneshot #(.NUM_CH(NCH), .CNT_W(CW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_fall_n (a),
        .trig_rise   (b),
        .clr_n       (clr),
        .width_cnt   ({w1, w0}),
        .q           (q),
        .q_n         (q_n)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: advance one clock
    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            int  wv;
            bit  fire;
            wv = (c == 0) ? int'(w0) : int'(w1);
            if (!rst_n) begin
                m_rem[c] = 0; m_a[c] = 0; m_b[c] = 1; m_c[c] = 0;
            end else begin
                fire = clr[c] && m_c[c] && m_rem[c] == 0 &&
                       ((m_a[c] && !a[c] && b[c]) || (!m_b[c] && b[c] && !a[c]));
                if (!clr[c])      m_rem[c] = 0;
                else if (fire)    m_rem[c] = (wv == 0) ? 1 : wv;
                else if (m_rem[c] > 0) m_rem[c] = m_rem[c] - 1;
                m_a[c] = a[c]; m_b[c] = b[c]; m_c[c] = clr[c];
            end
        end
    end

    // Per-cycle comparison with the model, plus complement check (R9)
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                check(q[c] == (m_rem[c] != 0), "model q", int'(q[c]), int'(m_rem[c] != 0));
                check(q_n[c] == ~q[c], "R9 complement", int'(q_n[c]), int'(~q[c]));
            end
        end
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic negs(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Count consecutive high cycles of q[ch] starting at the next falling edge
    task automatic measure(input int ch, output int cnt);
        cnt = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!q[ch]) break;
            cnt++;
        end
    endtask

    // Require q[ch] low for n sampled cycles
    task automatic stay_low(input int ch, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(q[ch] == 1'b0, tag, int'(q[ch]), 0);
        end
    endtask

    initial begin
        int len;
        int hi;
        negs(3);
        // R1: reset state
        check(q == '0 && q_n == '1, "R1 reset idle", int'(q), 0);
        @(negedge clk) rst_n = 1'b1;
        negs(2);
        check(q == '0, "R1 idle after release", int'(q), 0);

        // R2: falling trigger with rising trigger high
        a[0] = 1'b0;
        measure(0, len);
        check(len == 5, "R2 fall fires / R5 width 5", len, 5);
        a[0] = 1'b1; negs(2);

        // R4: falling edge while rising trigger low does nothing
        b[0] = 1'b0; negs(2);
        a[0] = 1'b0;
        stay_low(0, 3, "R4 inhibit by low rise-trigger");
        // R3: rising edge with falling trigger low
        b[0] = 1'b1;
        measure(0, len);
        check(len == 5, "R3 rise fires", len, 5);

        // R4: rising edge while falling trigger high does nothing
        a[0] = 1'b1; b[0] = 1'b0; negs(2);
        b[0] = 1'b1;
        stay_low(0, 4, "R4 inhibit by high fall-trigger");

        // R5: width one and width zero
        w0 = 8'd1; a[0] = 1'b0;
        measure(0, len);
        check(len == 1, "R5 width 1", len, 1);
        a[0] = 1'b1; negs(2);
        w0 = 8'd0; a[0] = 1'b0;
        measure(0, len);
        check(len == 1, "R5 width 0 acts as 1", len, 1);
        a[0] = 1'b1; negs(2);

        // R6: transitions during a pulse are ignored
        w0 = 8'd6; a[0] = 1'b0;
        hi = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (q[0]) hi++;
            if (i == 1) b[0] = 1'b0;
            if (i == 2) b[0] = 1'b1;
            if (i == 3) a[0] = 1'b1;
            if (i == 4) a[0] = 1'b0;
        end
        check(hi == 6, "R6 no retrigger", hi, 6);
        a[0] = 1'b1; negs(2);

        // R7: clear aborts and holds idle
        w0 = 8'd10; a[0] = 1'b0; negs(3);
        check(q[0] == 1'b1, "R7 pulse running before clear", int'(q[0]), 1);
        clr[0] = 1'b0;
        @(negedge clk);
        check(q[0] == 1'b0, "R7 clear ends pulse", int'(q[0]), 0);
        a[0] = 1'b1;
        stay_low(0, 2, "R7 held by clear");
        a[0] = 1'b0;
        stay_low(0, 3, "R7 held by clear");
        a[0] = 1'b1; negs(1);

        // R8: edge in the release cycle of clear is ignored
        clr[0] = 1'b1; a[0] = 1'b0;
        stay_low(0, 4, "R8 edge at clear release");
        a[0] = 1'b1; negs(1);
        a[0] = 1'b0;
        @(negedge clk);
        check(q[0] == 1'b1, "R8 control fire after setup", int'(q[0]), 1);
        negs(12);

        // R10: edge in last high cycle ignored
        w0 = 8'd3; a[0] = 1'b1; negs(2);
        a[0] = 1'b0;               // fires; q high at next 3 samples
        @(negedge clk) b[0] = 1'b0;
        negs(1);
        @(negedge clk) b[0] = 1'b1; // edge seen during last high cycle
        negs(1);
        check(q[0] == 1'b0, "R10 last-cycle edge ignored", int'(q[0]), 0);
        @(negedge clk);
        check(q[0] == 1'b0, "R10 last-cycle edge ignored", int'(q[0]), 0);
        // R10: edge right after the pulse ends starts a new one
        a[0] = 1'b1; negs(2);
        a[0] = 1'b0;
        @(negedge clk) b[0] = 1'b0;
        negs(2);
        check(q[0] == 1'b1, "R10 still in last cycle", int'(q[0]), 1);
        @(negedge clk);
        check(q[0] == 1'b0, "R10 pulse ended", int'(q[0]), 0);
        b[0] = 1'b1;
        measure(0, len);
        check(len == 3, "R10 back-to-back pulse", len, 3);

        // R11: channel 1 runs alone; clearing channel 0 leaves it intact
        a[0] = 1'b1; negs(2);
        w1 = 8'd4; a[1] = 1'b0;
        @(negedge clk) clr[0] = 1'b0;
        check(q[0] == 1'b0, "R11 channel 0 untouched", int'(q[0]), 0);
        hi = 1;
        measure(1, len);
        check(len + hi == 4, "R11 channel 1 width", len + hi, 4);
        clr[0] = 1'b1; a[1] = 1'b1; negs(3);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule